// File: doc/BRIEF.md
# Access Benchmark Counter Unit

This block measures how a memory is being used by counting two kinds of access: instruction fetches and data reads. Each count lives in its own 32-bit counter. Each counter has its own enable bit in a small control register, and each advances by one on every cycle in which its access strobe is high. Software reaches the block through a simple write port and a combinational read port. It can preset or zero either counter at any time, and it can program a threshold value.

A single equality comparator is shared by the two counters. A select bit in the control register chooses which counter it watches. The comparator has its own enable bit. When the watched counter arrives at the threshold, a match flag is raised in an interrupt flag register. That register has a per-bit enable register, a write-one-to-clear address and a write-one-to-set address. The remaining flag bits are driven by placeholder pulse inputs that stand in for other event sources. The interrupt output is high whenever an enabled flag is set.

Top module: `acc_bmk_unit`

## Requirements
- R1: An active-low asynchronous reset clears the control register, both counters, the threshold, the flag register and the enable register, and holds irq low.
- R2: While control bit 0 is 1, the instruction counter (address 1) rises by one on every cycle with fetch_stb high. While the bit is 0, the counter holds its value.
- R3: While control bit 1 is 1, the data counter (address 2) rises by one on every cycle with dread_stb high. While the bit is 0, the counter holds its value.
- R4: Software writes to address 1, 2 or 3 load the instruction counter, the data counter or the threshold. A counter write in the same cycle as an increment wins. The counters wrap from all-ones to zero.
- R5: Control bit 2 enables comparison. Control bit 3 picks the counter compared: 0 for the instruction counter, 1 for the data counter. On the first cycle in which comparison is enabled and the chosen counter equals the threshold, flag bit 8 (address 4) is set on the next clock edge. It is not set again while the equality persists.
- R6: Writing to address 6 clears every flag bit written as 1. Writing to address 7 sets every flag bit written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R7: The enable register is written and read at address 5. irq is the OR over all flag bits of each flag ANDed with its enable bit, taken from the registered flags.
- R8: A pulse on bit k of ext_flags sets flag bit k. A write to address 4 leaves the flags unchanged.
- R9: Address 0 holds the control value in bits 3:0. Addresses 6 and 7 read as zero. All read values are zero-extended to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_stb | input | 1 | One instruction fetch this cycle |
| dread_stb | input | 1 | One data read this cycle |
| ext_flags | input | FLAG_W | Placeholder set pulses for the flag register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong counter value shows up at the read port one cycle after the faulty edge, and it persists because counters only accumulate. A stuck comparator history bit has two visible effects: the match flag either never appears, or it reappears right after a clear while the equality persists. Both show at address 4 and on irq on the cycle after the edge. A bad flag or enable bit shows on irq in the same cycle it is read. The bench therefore compares the read port and irq against a behavioural model on every cycle, with the read address rotating.

// File: rtl/acc_bmk_pkg.sv
package acc_bmk_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 3'd0,
      RA_ICNT = 3'd1,
      RA_DCNT = 3'd2,
      RA_THR  = 3'd3,
      RA_FLAG = 3'd4,
      RA_IEN  = 3'd5,
      RA_FCLR = 3'd6,
      RA_FSET = 3'd7
   } acc_bmk_addr_e;

   localparam int CTL_W      = 4;
   localparam int CB_IEN     = 0;
   localparam int CB_DEN     = 1;
   localparam int CB_CMP_EN  = 2;
   localparam int CB_CMP_SEL = 3;
endpackage

// File: rtl/acc_bmk_counter.sv
module acc_bmk_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         stb,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (ld)         cnt <= ld_val;
      else if (en && stb)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/acc_bmk_match.sv
module acc_bmk_match #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_en,
   input  logic         sel,
   input  logic [W-1:0] cnt_a,
   input  logic [W-1:0] cnt_b,
   input  logic [W-1:0] thr,
   output logic         hit
);
   logic eq_now;
   logic eq_prev;

   assign eq_now = cmp_en && ((sel ? cnt_b : cnt_a) == thr);
   assign hit    = eq_now && !eq_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_prev <= 1'b0;
      else        eq_prev <= eq_now;
   end
endmodule

// File: rtl/acc_bmk_flags.sv
module acc_bmk_flags #(
   parameter int FW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] set_vec,
   input  logic [FW-1:0] clr_vec,
   input  logic          ien_ld,
   input  logic [FW-1:0] ien_val,
   output logic [FW-1:0] flags,
   output logic [FW-1:0] ien,
   output logic          irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         ien   <= '0;
      end else begin
         flags <= (flags & ~clr_vec) | set_vec;
         if (ien_ld) ien <= ien_val;
      end
   end

   assign irq = |(flags & ien);
endmodule

// File: rtl/acc_bmk_unit.sv
module acc_bmk_unit
   import acc_bmk_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int FLAG_W    = 10,
   parameter int MATCH_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_stb,
   input  logic              dread_stb,
   input  logic [FLAG_W-1:0] ext_flags,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int NCNT = 2;

   if (MATCH_BIT >= FLAG_W) begin : g_bad_match_bit
      $error("MATCH_BIT must lie inside the flag register");
   end
   if (DATA_W < CNT_W || DATA_W < FLAG_W || DATA_W < CTL_W) begin : g_bad_data_w
      $error("DATA_W must cover counters, flags and control");
   end

   logic [CTL_W-1:0]  ctl_q;
   logic [CNT_W-1:0]  thr_q;
   logic [CNT_W-1:0]  cnt_q [NCNT];
   logic [CNT_W-1:0]  cnt_i;
   logic [CNT_W-1:0]  cnt_d;
   logic [NCNT-1:0]   stb_vec;
   logic              hit;
   logic [FLAG_W-1:0] flg_q;
   logic [FLAG_W-1:0] ien_q;
   logic [FLAG_W-1:0] set_vec;
   logic [FLAG_W-1:0] clr_vec;
   logic [FLAG_W-1:0] hit_vec;

   assign stb_vec = {dread_stb, fetch_stb};

   for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
      localparam logic [2:0] LD_ADDR = (gi == 0) ? RA_ICNT : RA_DCNT;
      acc_bmk_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ctl_q[CB_IEN + gi]),
         .stb   (stb_vec[gi]),
         .ld    (wr_en && (wr_addr == LD_ADDR)),
         .ld_val(wr_data[CNT_W-1:0]),
         .cnt   (cnt_q[gi])
      );
   end

   assign cnt_i = cnt_q[0];
   assign cnt_d = cnt_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         thr_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == RA_CTRL) ctl_q <= wr_data[CTL_W-1:0];
         if (wr_addr == RA_THR)  thr_q <= wr_data[CNT_W-1:0];
      end
   end

   acc_bmk_match #(.W(CNT_W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .cmp_en(ctl_q[CB_CMP_EN]),
      .sel   (ctl_q[CB_CMP_SEL]),
      .cnt_a (cnt_i),
      .cnt_b (cnt_d),
      .thr   (thr_q),
      .hit   (hit)
   );

   always_comb begin
      hit_vec            = '0;
      hit_vec[MATCH_BIT] = hit;
      set_vec = ext_flags | hit_vec;
      clr_vec = '0;
      if (wr_en && wr_addr == RA_FSET) set_vec = set_vec | wr_data[FLAG_W-1:0];
      if (wr_en && wr_addr == RA_FCLR) clr_vec = wr_data[FLAG_W-1:0];
   end

   acc_bmk_flags #(.FW(FLAG_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .ien_ld (wr_en && wr_addr == RA_IEN),
      .ien_val(wr_data[FLAG_W-1:0]),
      .flags  (flg_q),
      .ien    (ien_q),
      .irq    (irq)
   );

   always_comb begin
      case (rd_addr)
         RA_CTRL: rd_data = DATA_W'(ctl_q);
         RA_ICNT: rd_data = DATA_W'(cnt_i);
         RA_DCNT: rd_data = DATA_W'(cnt_d);
         RA_THR:  rd_data = DATA_W'(thr_q);
         RA_FLAG: rd_data = DATA_W'(flg_q);
         RA_IEN:  rd_data = DATA_W'(ien_q);
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/acc_bmk_chk.sv
module acc_bmk_chk
   import acc_bmk_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int FLAG_W    = 10,
   parameter int MATCH_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_stb,
   input logic              dread_stb,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CTL_W-1:0]  ctl,
   input logic [CNT_W-1:0]  cnt_i,
   input logic [CNT_W-1:0]  cnt_d,
   input logic [CNT_W-1:0]  thr,
   input logic [FLAG_W-1:0] flags,
   input logic [FLAG_W-1:0] ien,
   input logic              irq
);
   logic watch_eq;
   assign watch_eq = ctl[CB_CMP_EN] &&
                     ((ctl[CB_CMP_SEL] ? cnt_d : cnt_i) == thr);

   assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_addr == RA_ICNT) && ctl[CB_IEN] && fetch_stb)
      |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

   assert_dread_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_addr == RA_DCNT) && !(ctl[CB_DEN] && dread_stb))
      |=> $stable(cnt_d));

   assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_ICNT)
      |=> cnt_i == $past(wr_data[CNT_W-1:0]));

   assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_eq && !($past(ctl[CB_CMP_EN]) &&
        (($past(ctl[CB_CMP_SEL]) ? $past(cnt_d) : $past(cnt_i)) == $past(thr))))
      |=> flags[MATCH_BIT]);

   assert_set_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_FSET)
      |=> (flags & $past(wr_data[FLAG_W-1:0])) == $past(wr_data[FLAG_W-1:0]));

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);
endmodule

bind acc_bmk_unit acc_bmk_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W), .MATCH_BIT(MATCH_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fetch_stb(fetch_stb),
   .dread_stb(dread_stb),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .ctl      (ctl_q),
   .cnt_i    (cnt_i),
   .cnt_d    (cnt_d),
   .thr      (thr_q),
   .flags    (flg_q),
   .ien      (ien_q),
   .irq      (irq)
);

// File: tb/acc_bmk_unit_tb_top.sv
module acc_bmk_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        fetch_stb, dread_stb;
   logic [9:0]  ext_flags;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic [2:0]  rd_addr;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   // behavioural reference state
   logic [3:0]  m_ctl;
   logic [31:0] m_ci, m_cd, m_thr;
   logic [9:0]  m_flg, m_ien;
   bit          m_prev;

   always #10 clk = ~clk;

   acc_bmk_unit dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .dread_stb(dread_stb),
      .ext_flags(ext_flags), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return {28'd0, m_ctl};
         3'd1: return m_ci;
         3'd2: return m_cd;
         3'd3: return m_thr;
         3'd4: return {22'd0, m_flg};
         3'd5: return {22'd0, m_ien};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] a);
      case (a)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit          eq;
      logic [9:0]  setv, clrv;
      logic [31:0] ci, cd;
      eq   = m_ctl[2] && ((m_ctl[3] ? m_cd : m_ci) == m_thr);
      setv = ext_flags;
      clrv = '0;
      if (eq && !m_prev) setv[8] = 1'b1;
      ci = m_ci; cd = m_cd;
      if (m_ctl[0] && fetch_stb) ci = ci + 1;
      if (m_ctl[1] && dread_stb) cd = cd + 1;
      if (wr_en) begin
         case (wr_addr)
            3'd0: m_ctl = wr_data[3:0];
            3'd1: ci = wr_data;
            3'd2: cd = wr_data;
            3'd3: m_thr = wr_data;
            3'd5: m_ien = wr_data[9:0];
            3'd6: clrv = wr_data[9:0];
            3'd7: setv = setv | wr_data[9:0];
            default: ;
         endcase
      end
      m_ci = ci; m_cd = cd;
      m_flg = (m_flg & ~clrv) | setv;
      m_prev = eq;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag_of(rd_addr), rd_data, m_read(rd_addr));
      chk("R7", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
      rd_addr = rd_addr + 3'd1;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic peek(string tag, logic [2:0] a, logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; fetch_stb = 0; dread_stb = 0; ext_flags = '0;
      wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      m_ctl = '0; m_ci = '0; m_cd = '0; m_thr = '0; m_flg = '0; m_ien = '0; m_prev = 0;
      repeat (3) @(negedge clk);
      for (int a = 0; a < 8; a++) peek("R1", 3'(a), 32'd0);
      chk("R1", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // both counters running under mixed strobes
      wr(3'd0, 32'h3);
      for (int i = 0; i < 40; i++) begin
         fetch_stb = (i % 3) != 0; dread_stb = (i % 2) == 0;
         cyc();
      end
      fetch_stb = 0; dread_stb = 0;

      // R3: data counter frozen while its enable is clear
      wr(3'd0, 32'h1);
      fetch_stb = 1; dread_stb = 1;
      repeat (5) cyc();
      fetch_stb = 0; dread_stb = 0;
      peek("R3", 3'd2, m_cd);
      peek("R2", 3'd1, m_ci);

      // R4: write beats increment, and wrap
      fetch_stb = 1;
      wr(3'd1, 32'h0000_0100);
      peek("R4", 3'd1, 32'h0000_0100);
      wr(3'd1, 32'hFFFF_FFFF);
      cyc();
      fetch_stb = 0;
      peek("R4", 3'd1, 32'h0000_0000);

      // R5: instruction counter reaches threshold once
      wr(3'd3, 32'd10);
      wr(3'd1, 32'd7);
      wr(3'd0, 32'h5);
      fetch_stb = 1;
      repeat (3) cyc();
      fetch_stb = 0;
      cyc();
      peek("R5", 3'd4, 32'h100);
      wr(3'd6, 32'h100);
      repeat (3) cyc();
      peek("R5", 3'd4, 32'h000);
      // data counter selected
      wr(3'd2, 32'd9);
      wr(3'd0, 32'hE);
      dread_stb = 1;
      cyc();
      dread_stb = 0;
      cyc();
      peek("R5", 3'd4, 32'h100);
      wr(3'd0, 32'h0);

      // R6: set and clear registers, set wins against clear
      wr(3'd6, 32'h3FF);
      wr(3'd7, 32'h021);
      peek("R6", 3'd4, 32'h021);
      ext_flags = 10'h001;
      wr(3'd6, 32'h021);
      ext_flags = '0;
      peek("R6", 3'd4, 32'h001);
      peek("R9", 3'd6, 32'd0);

      // R7: interrupt gating
      wr(3'd5, 32'h002);
      chk("R7", {31'd0, irq}, 32'd0);
      wr(3'd5, 32'h001);
      chk("R7", {31'd0, irq}, 32'd1);

      // R8: external pulses set, direct flag writes ignored
      ext_flags = 10'h208;
      cyc();
      ext_flags = '0;
      wr(3'd4, 32'h000);
      peek("R8", 3'd4, 32'h209);

      // randomised traffic against the model
      for (int i = 0; i < 600; i++) begin
         fetch_stb = 1'($urandom);
         dread_stb = 1'($urandom);
         ext_flags = ($urandom % 8 == 0) ? 10'($urandom) : '0;
         if ($urandom % 4 == 0) begin
            wr_en = 1'b1; wr_addr = 3'($urandom);
            wr_data = (wr_addr == 3'd1 || wr_addr == 3'd2 || wr_addr == 3'd3)
                      ? 32'($urandom % 24) : $urandom;
         end
         cyc();
         wr_en = 1'b0;
      end
      ext_flags = '0; fetch_stb = 0; dread_stb = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule